// File: doc/BRIEF.md
# Word-Interleaved Banked Memory Crossbar

This block sits between a group of requesting masters (compute cores, a copy engine, a bus bridge) and a set of on-chip memory banks that it holds itself. Consecutive 32-bit words live in consecutive banks. Streaming or strided accesses from different masters therefore tend to land on different banks, and all of them are served together.

Every bank has its own round-robin arbiter. A master raises a request with its write flag, byte enables, byte address and write data, and it is granted in the same cycle if it wins its bank. A master that loses holds its request until it is granted. A granted read returns the whole word, with a valid strobe, on the following cycle. A granted write updates only the bytes that are enabled. The memory arrays are plain register arrays with no reset.

Each arbiter has one state register, its priority pointer. In the state "idle" no master targets the bank, and the pointer holds. In the state "serve k" master k wins, and the transition "advance" moves the pointer to k+1, wrapping to 0 after the last master.

Top module: `wi_bank_xbar`

## Requirements
- R1: The bank is taken from the byte-address bits just above the 2-bit byte offset, so the bank is `addr[2 +: log2(NUM_BANKS)]`. The row is taken from the next `log2(BANK_WORDS)` bits. All higher address bits are ignored, so such addresses alias.
- R2: A bank that has at least one request grants exactly one of those requests in the same cycle. A lone request is granted at once.
- R3: Masters that target pairwise different banks are all granted in the same cycle.
- R4: A bank never grants more than one master per cycle, and `gnt_o[m]` is high only while `req_i[m]` is high.
- R5: Each bank's priority starts at master 0 after reset. The bank grants the first requesting master at or after its pointer, counting cyclically. After granting master k, the pointer moves to k+1 (wrapping to 0). The pointer does not change in a cycle with no grant.
- R6: For a read granted in cycle t, `rvalid_o[m]` is high in cycle t+1, and `rdata_o` slice m holds the full 32-bit word last written to that location.
- R7: On a granted write, byte-enable bit k (the LSB is k=0) updates data bits 8k+7..8k of the word. The other bytes keep their old values.
- R8: A granted write does not raise `rvalid_o` in the following cycle.
- R9: While reset is held and in the first cycle after it, `rvalid_o` is all zero. With no requests, `gnt_o` is all zero.
- R10: A request that is not granted neither changes memory nor produces `rvalid_o`. When the same request is granted later, it takes effect as if it had just been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_MASTERS | Request, one bit per master |
| we_i | input | NUM_MASTERS | Write flag per master (1 = write) |
| be_i | input | 4*NUM_MASTERS | Byte enables, 4 bits per master |
| addr_i | input | 32*NUM_MASTERS | Byte address per master |
| wdata_i | input | 32*NUM_MASTERS | Write data per master |
| gnt_o | output | NUM_MASTERS | Grant per master, same cycle as the request |
| rvalid_o | output | NUM_MASTERS | Read data valid, one cycle after a read grant |
| rdata_o | output | 32*NUM_MASTERS | Read data per master |

## Verification
The hardest situation to reach is sustained contention in which the pointers wrap. In that case a master reads a word that a rival master wrote to the same bank only a cycle or two earlier, while the reader's own request has been held back by losing arbitration. The random phase restricts addresses to four rows in every bank and holds each request until it is granted. Many masters then pile onto few banks, and pointer wrap, held requests and read-after-write races happen constantly. A bench-side model of the pointers and memory predicts each grant vector and read word. Directed cases cover the full rotation on one bank, all banks granted in parallel, and a partial byte write.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BYTES  = WORD_W / 8;
    localparam int unsigned OFS_W  = $clog2(BYTES);
    localparam int unsigned ADDR_W = 32;
endpackage

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb #(
    parameter int unsigned NREQ = 10
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [NREQ-1:0] req_i,
    output logic [NREQ-1:0] gnt_o,
    output logic            any_o
);
    localparam int unsigned IDX_W = (NREQ > 1) ? $clog2(NREQ) : 1;

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] win;

    always_comb begin
        gnt_o = '0;
        any_o = 1'b0;
        win   = '0;
        for (int k = 0; k < NREQ; k++) begin
            int idx;
            idx = int'(ptr_q) + k;
            if (idx >= NREQ) idx = idx - NREQ;
            if (!any_o && req_i[idx]) begin
                gnt_o[idx] = 1'b1;
                any_o      = 1'b1;
                win        = IDX_W'(idx);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else if (any_o) begin
            if (win == IDX_W'(NREQ - 1)) ptr_q <= '0;
            else                         ptr_q <= win + 1'b1;
        end
    end

    a_r4_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));
    a_r2_work_conserving: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i != '0) |-> (gnt_o != '0));

    for (genvar i = 0; i < NREQ; i++) begin : g_fair
        a_r5_no_repeat: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (gnt_o[i] && $countones(req_i) > 1) ##1 (req_i == $past(req_i)) |-> !gnt_o[i]);
    end
endmodule

// File: rtl/xbar_bank.sv
module xbar_bank #(
    parameter int unsigned WORDS = 128,
    parameter int unsigned ROW_W = $clog2(WORDS)
) (
    input  logic                          clk_i,
    input  logic                          en_i,
    input  logic                          we_i,
    input  logic [xbar_pkg::BYTES-1:0]    be_i,
    input  logic [ROW_W-1:0]              row_i,
    input  logic [xbar_pkg::WORD_W-1:0]   wdata_i,
    output logic [xbar_pkg::WORD_W-1:0]   rdata_o
);
    import xbar_pkg::*;

    logic [WORD_W-1:0] mem [WORDS];
    logic [WORD_W-1:0] rdata_q;

    always_ff @(posedge clk_i) begin
        if (en_i) begin
            if (we_i) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (be_i[b]) mem[row_i][8*b +: 8] <= wdata_i[8*b +: 8];
                end
            end else begin
                rdata_q <= mem[row_i];
            end
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/wi_bank_xbar.sv
module wi_bank_xbar #(
    parameter int unsigned NUM_MASTERS = 10,
    parameter int unsigned NUM_BANKS   = 16,
    parameter int unsigned BANK_WORDS  = 128
) (
    input  logic                                       clk_i,
    input  logic                                       rst_ni,
    input  logic [NUM_MASTERS-1:0]                     req_i,
    input  logic [NUM_MASTERS-1:0]                     we_i,
    input  logic [NUM_MASTERS*xbar_pkg::BYTES-1:0]     be_i,
    input  logic [NUM_MASTERS*xbar_pkg::ADDR_W-1:0]    addr_i,
    input  logic [NUM_MASTERS*xbar_pkg::WORD_W-1:0]    wdata_i,
    output logic [NUM_MASTERS-1:0]                     gnt_o,
    output logic [NUM_MASTERS-1:0]                     rvalid_o,
    output logic [NUM_MASTERS*xbar_pkg::WORD_W-1:0]    rdata_o
);
    import xbar_pkg::*;

    localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int unsigned ROW_W  = $clog2(BANK_WORDS);

    initial begin
        if ((1 << $clog2(NUM_BANKS)) != NUM_BANKS || NUM_BANKS < 2)
            $error("bank count must be a power of two");
    end

    logic [BANK_W-1:0]      m_bank  [NUM_MASTERS];
    logic [ROW_W-1:0]       m_row   [NUM_MASTERS];
    logic [NUM_MASTERS-1:0] b_req   [NUM_BANKS];
    logic [NUM_MASTERS-1:0] b_gnt   [NUM_BANKS];
    logic                   b_en    [NUM_BANKS];
    logic                   b_we    [NUM_BANKS];
    logic [BYTES-1:0]       b_be    [NUM_BANKS];
    logic [ROW_W-1:0]       b_row   [NUM_BANKS];
    logic [WORD_W-1:0]      b_wdata [NUM_BANKS];
    logic [WORD_W-1:0]      b_rdata [NUM_BANKS];
    logic [BANK_W-1:0]      rbank_q [NUM_MASTERS];
    logic [NUM_MASTERS-1:0] rvalid_q;

    // address split: word offset, then bank, then row
    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_dec
        assign m_bank[m] = addr_i[m*ADDR_W + OFS_W +: BANK_W];
        assign m_row[m]  = addr_i[m*ADDR_W + OFS_W + BANK_W +: ROW_W];
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_comb begin
            for (int m = 0; m < NUM_MASTERS; m++)
                b_req[b][m] = req_i[m] && (m_bank[m] == BANK_W'(b));
        end

        xbar_rr_arb #(.NREQ(NUM_MASTERS)) u_arb (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .req_i  (b_req[b]),
            .gnt_o  (b_gnt[b]),
            .any_o  (b_en[b])
        );

        always_comb begin
            b_we[b]    = 1'b0;
            b_be[b]    = '0;
            b_row[b]   = '0;
            b_wdata[b] = '0;
            for (int m = 0; m < NUM_MASTERS; m++) begin
                if (b_gnt[b][m]) begin
                    b_we[b]    = b_we[b]    | we_i[m];
                    b_be[b]    = b_be[b]    | be_i[m*BYTES +: BYTES];
                    b_row[b]   = b_row[b]   | m_row[m];
                    b_wdata[b] = b_wdata[b] | wdata_i[m*WORD_W +: WORD_W];
                end
            end
        end

        xbar_bank #(.WORDS(BANK_WORDS), .ROW_W(ROW_W)) u_mem (
            .clk_i   (clk_i),
            .en_i    (b_en[b]),
            .we_i    (b_we[b]),
            .be_i    (b_be[b]),
            .row_i   (b_row[b]),
            .wdata_i (b_wdata[b]),
            .rdata_o (b_rdata[b])
        );
    end

    always_comb begin
        gnt_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) gnt_o = gnt_o | b_gnt[b];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rvalid_q <= '0;
            for (int m = 0; m < NUM_MASTERS; m++) rbank_q[m] <= '0;
        end else begin
            rvalid_q <= gnt_o & ~we_i;
            for (int m = 0; m < NUM_MASTERS; m++)
                if (gnt_o[m]) rbank_q[m] <= m_bank[m];
        end
    end

    assign rvalid_o = rvalid_q;

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_resp
        assign rdata_o[m*WORD_W +: WORD_W] = b_rdata[rbank_q[m]];

        a_r4_grant_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
            gnt_o[m] |-> req_i[m]);
        a_r6_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (gnt_o[m] && !we_i[m]) |=> rvalid_o[m]);
        a_r8_write_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (gnt_o[m] && we_i[m]) |=> !rvalid_o[m]);
        a_r10_wait_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !gnt_o[m] |=> !rvalid_o[m]);
    end
endmodule

// File: tb/wi_bank_xbar_tb.sv
module wi_bank_xbar_tb;
    localparam int NM = 10;
    localparam int NB = 16;
    localparam int NW = 128;
    localparam int IDXB = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NM-1:0]    req, we, gnt, rvalid;
    logic [NM*4-1:0]  be;
    logic [NM*32-1:0] addr, wdata, rdata;

    always #5 clk = ~clk;

    wi_bank_xbar #(.NUM_MASTERS(NM), .NUM_BANKS(NB), .BANK_WORDS(NW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .be_i(be),
        .addr_i(addr), .wdata_i(wdata), .gnt_o(gnt), .rvalid_o(rvalid), .rdata_o(rdata));

    int total = 0, bad = 0;
    bit done = 1'b0;

    bit          p_act [NM];
    bit          p_we  [NM];
    logic [3:0]  p_be  [NM];
    logic [31:0] p_addr[NM];
    logic [31:0] p_wd  [NM];
    logic [31:0] mdl   [2**IDXB];
    int          ptr   [NB];
    bit          rd_pend [NM];
    logic [31:0] rd_exp  [NM];
    logic [NM-1:0] last_gnt;

    function automatic int bank_of(logic [31:0] a);
        return int'(a[5:2]);
    endfunction
    function automatic int idx_of(logic [31:0] a);
        return int'(a[2 +: IDXB]);
    endfunction
    function automatic logic [31:0] mk_addr(int bank, int row);
        logic [18:0] hi;
        hi = 19'($urandom());
        return {hi, 7'(row), 4'(bank), 2'b00};
    endfunction
    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] e);
        logic [31:0] r;
        r = o;
        for (int k = 0; k < 4; k++) if (e[k]) r[8*k +: 8] = n[8*k +: 8];
        return r;
    endfunction

    task automatic chk(bit ok, string req_tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, predict grants, check read returns at next negedge
    task automatic cycle();
        logic [NM-1:0] exp_g;
        for (int m = 0; m < NM; m++) begin
            req[m]          = p_act[m];
            we[m]           = p_we[m];
            be[m*4 +: 4]    = p_be[m];
            addr[m*32 +: 32]  = p_addr[m];
            wdata[m*32 +: 32] = p_wd[m];
        end
        #1;
        exp_g = '0;
        for (int b = 0; b < NB; b++) begin
            for (int k = 0; k < NM; k++) begin
                int m;
                m = (ptr[b] + k) % NM;
                if (p_act[m] && bank_of(p_addr[m]) == b) begin
                    exp_g[m] = 1'b1;
                    ptr[b] = (m + 1) % NM;
                    break;
                end
            end
        end
        chk(gnt == exp_g, "R2 R3 R4 R5 grant vector", 64'(gnt), 64'(exp_g));
        last_gnt = gnt;
        for (int m = 0; m < NM; m++) begin
            rd_pend[m] = 1'b0;
            if (exp_g[m]) begin
                if (p_we[m]) mdl[idx_of(p_addr[m])] = merge(mdl[idx_of(p_addr[m])], p_wd[m], p_be[m]);
                else begin
                    rd_pend[m] = 1'b1;
                    rd_exp[m]  = mdl[idx_of(p_addr[m])];
                end
                p_act[m] = 1'b0;
            end
        end
        @(negedge clk);
        for (int m = 0; m < NM; m++) begin
            chk(rvalid[m] == rd_pend[m], "R6 R8 R10 rvalid", 64'(rvalid[m]), 64'(rd_pend[m]));
            if (rd_pend[m])
                chk(rdata[m*32 +: 32] === rd_exp[m], "R1 R6 R7 R10 read data",
                    64'(rdata[m*32 +: 32]), 64'(rd_exp[m]));
        end
    endtask

    task automatic drain();
        for (int n = 0; n < 100; n++) begin
            bit any;
            any = 1'b0;
            for (int m = 0; m < NM; m++) any |= p_act[m];
            if (!any) break;
            cycle();
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int b = 0; b < NB; b++) ptr[b] = 0;
        for (int m = 0; m < NM; m++) begin
            p_act[m] = 0; p_we[m] = 0; p_be[m] = 0; p_addr[m] = 0; p_wd[m] = 0;
        end
        req = '0; we = '0; be = '0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(rvalid == '0, "R9 rvalid in reset", 64'(rvalid), 64'(0));
        chk(gnt == '0, "R9 no grant without request", 64'(gnt), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(rvalid == '0, "R9 rvalid after reset", 64'(rvalid), 64'(0));

        // fill 4 rows of every bank with full-word writes
        for (int w = 0; w < 4 * NB; ) begin
            for (int m = 0; m < NM && w < 4 * NB; m++) begin
                if (!p_act[m]) begin
                    p_act[m] = 1; p_we[m] = 1; p_be[m] = 4'hF;
                    p_addr[m] = mk_addr(w % NB, w / NB); p_wd[m] = $urandom();
                    w++;
                end
            end
            cycle();
        end
        drain();

        // R7: partial byte write, then explicit readback
        begin
            logic [31:0] old, want;
            old = mdl[5];
            p_act[3] = 1; p_we[3] = 1; p_be[3] = 4'b0101; p_addr[3] = mk_addr(5, 0); p_wd[3] = 32'hAAAA_AAAA;
            drain();
            p_act[3] = 1; p_we[3] = 0; p_addr[3] = mk_addr(5, 0);
            cycle();
            want = (old & 32'hFF00_FF00) | 32'h00AA_00AA;
            chk(rdata[3*32 +: 32] == want, "R7 byte enables", 64'(rdata[3*32 +: 32]), 64'(want));
        end

        // R5: all masters on one bank, full rotation from current pointer
        begin
            int start;
            start = ptr[7];
            for (int m = 0; m < NM; m++) begin
                p_act[m] = 1; p_we[m] = 0; p_addr[m] = mk_addr(7, m % 4);
            end
            for (int k = 0; k < NM; k++) begin
                cycle();
                chk(last_gnt == NM'(1) << ((start + k) % NM), "R5 rotation order",
                    64'(last_gnt), 64'(NM'(1) << ((start + k) % NM)));
            end
        end

        // R3: every master to its own bank, all granted together
        for (int m = 0; m < NM; m++) begin
            p_act[m] = 1; p_we[m] = (m % 2 == 1); p_be[m] = 4'hF;
            p_addr[m] = mk_addr(m, m % 4); p_wd[m] = $urandom();
        end
        cycle();
        chk(last_gnt == {NM{1'b1}}, "R3 parallel grant", 64'(last_gnt), 64'({NM{1'b1}}));

        // random contention on a small window
        for (int n = 0; n < 3000; n++) begin
            for (int m = 0; m < NM; m++) begin
                if (!p_act[m] && ($urandom() % 4 != 0)) begin
                    p_act[m] = 1;
                    p_we[m]  = $urandom() % 2;
                    p_be[m]  = 4'($urandom());
                    p_addr[m] = mk_addr($urandom() % NB, $urandom() % 4);
                    p_wd[m]  = $urandom();
                end
            end
            cycle();
        end
        drain();
        cycle();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule